// File: doc/BRIEF.md
# Byte ALU with Accumulator and Condition Flags

This block is the execution stage of a small byte-wide microcontroller. Each cycle with `exec_i` high it takes an opcode, the value of a register, and a second operand, and then updates its state on the clock edge. The second operand may be an immediate, a second register or a data-memory byte; the block does not care which. The state is the accumulator, the carry (C), overflow (V) and zero (Z) flags, and a destination result with a one-cycle write strobe. The C flag feeds back into the carry-using operations.

The block covers these operations:

- add, and add with carry;
- reverse subtract (operand minus register) and straight subtract (register minus operand), each with and without carry;
- decrement, and decrement with carry;
- AND, OR and XOR;
- unsigned and signed compare;
- single-bit test, set, clear and invert.

After every subtract, decrement and compare, carry holds the inverse of the borrow. Every operation copies its byte result into the accumulator. Instruction decode, the register file and memory lie outside the block.

Top module: `alu8_core`

## Requirements
- R1: Opcode encoding on `op_i`:

  | Code | Operation | Code | Operation |
  |------|-----------|------|-----------|
  | 0 | add | 9 | OR |
  | 1 | add with carry | 10 | XOR |
  | 2 | reverse subtract | 11 | unsigned compare |
  | 3 | reverse subtract with carry | 12 | signed compare |
  | 4 | straight subtract | 13 | bit test |
  | 5 | straight subtract with carry | 14 | bit set |
  | 6 | decrement | 15 | bit clear |
  | 7 | decrement with carry | 16 | bit invert |
  | 8 | AND | | |

  Every executed operation loads its byte result into `acc_o`, and sets `z_o` to 1 exactly when that byte is zero. The update is visible one clock after `exec_i` is sampled high.
- R2: Add forms compute reg + operand. The carry form also adds the incoming C. C becomes the carry out of the top bit, and V becomes two's-complement overflow.
- R3: Reverse subtract gives operand − reg and straight subtract gives reg − operand. The carry forms subtract an extra (1 − C). C becomes 0 on underflow and 1 otherwise, and V becomes signed overflow.
- R4: Decrement gives operand − 1, and decrement with carry gives operand − (1 − C). C is cleared only when the subtraction borrows, that is when the result is 0xFF coming from a borrow. V is signed overflow.
- R5: AND, OR and XOR of reg and operand change only the accumulator and Z. C and V keep their values.
- R6: Unsigned compare evaluates operand − reg into the accumulator. It never raises the write strobe. C is the inverted borrow, and V is then C AND NOT Z.
- R7: Signed compare treats both bytes as two's-complement values. The accumulator still gets operand − reg. C is 1 exactly when operand ≥ reg as signed values, V is C AND NOT Z, and no write is made.
- R8: Bit test copies bit k of reg into bit k of the accumulator and clears every other bit. It does not write the register and keeps C and V. Here k is `opnd_i[2:0]`.
- R9: Bit set, clear and invert change only bit k of reg, with k = `opnd_i[2:0]`. The result goes to `res_o` and the accumulator, and C and V are kept.
- R10: For every operation except compare and bit test, `res_we_o` pulses for one cycle with `res_o` equal to `acc_o`. Otherwise `res_we_o` is 0.
- R11: While `exec_i` is low, or when it is high with an opcode above 16, the accumulator, flags and `res_o` keep their values and `res_we_o` is 0.
- R12: While `rst_ni` is low: the accumulator and `res_o` are 0, C and V are 0, Z is 1, and `res_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute the operation presented this cycle |
| op_i | input | 5 | Opcode (encoding in R1) |
| reg_i | input | W | Register operand |
| opnd_i | input | W | Second operand; low bits give the bit index for bit operations |
| res_o | output | W | Value for the destination register |
| res_we_o | output | 1 | Destination write strobe, one cycle |
| acc_o | output | W | Accumulator |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Overflow / compare-greater flag |
| z_o | output | 1 | Zero flag |

## Verification
The bench builds the block with its default width W = 8. This keeps the whole operand space small enough that the sign boundaries 0x7F/0x80 and the wrap points 0x00/0xFF can be aimed at directly, and each of the eight bit indices can be named.

A fixed vector table sets the incoming carry explicitly before each entry. It exercises borrow and wrap corners such as decrement with carry from 0x00 under both C values, and signed compare across the sign boundary.

A long random run then feeds random operations and operands to the block. The incoming carry follows whatever the previous operation left, so both C values reach every carry-using form.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUBR  = 5'd2,
    OP_SUBRC = 5'd3,
    OP_SUBS  = 5'd4,
    OP_SUBSC = 5'd5,
    OP_DEC   = 5'd6,
    OP_DECC  = 5'd7,
    OP_AND   = 5'd8,
    OP_OR    = 5'd9,
    OP_XOR   = 5'd10,
    OP_CMP   = 5'd11,
    OP_CMPS  = 5'd12,
    OP_TSTB  = 5'd13,
    OP_SETB  = 5'd14,
    OP_CLRB  = 5'd15,
    OP_INVB  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG
  } cin_sel_e;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR
  } log_fn_e;

  typedef enum logic [1:0] {
    BIT_TST,
    BIT_SET,
    BIT_CLR,
    BIT_INV
  } bit_fn_e;

  typedef struct packed {
    logic     valid;
    logic     use_adder;
    logic     sub;
    logic     a_is_reg;
    logic     b_zero;
    cin_sel_e cin_sel;
    logic     signed_cmp;
    logic     is_cmp;
    log_fn_e  log_fn;
    bit_fn_e  bit_fn;
    logic     is_bit;
    logic     wr_reg;
    logic     upd_cv;
  } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output alu_ctrl_t       ctrl_o
);

  always_comb begin
    ctrl_o            = '0;
    ctrl_o.cin_sel    = CIN_ZERO;
    ctrl_o.log_fn     = LOG_AND;
    ctrl_o.bit_fn     = BIT_TST;
    ctrl_o.valid      = 1'b1;
    ctrl_o.wr_reg     = 1'b1;
    case (op_i)
      OP_ADD, OP_ADDC: begin
        ctrl_o.use_adder = 1'b1;
        ctrl_o.a_is_reg  = 1'b1;
        ctrl_o.upd_cv    = 1'b1;
        ctrl_o.cin_sel   = (op_i == OP_ADDC) ? CIN_FLAG : CIN_ZERO;
      end
      OP_SUBR, OP_SUBRC: begin
        ctrl_o.use_adder = 1'b1;
        ctrl_o.sub       = 1'b1;
        ctrl_o.upd_cv    = 1'b1;
        ctrl_o.cin_sel   = (op_i == OP_SUBRC) ? CIN_FLAG : CIN_ONE;
      end
      OP_SUBS, OP_SUBSC: begin
        ctrl_o.use_adder = 1'b1;
        ctrl_o.sub       = 1'b1;
        ctrl_o.a_is_reg  = 1'b1;
        ctrl_o.upd_cv    = 1'b1;
        ctrl_o.cin_sel   = (op_i == OP_SUBSC) ? CIN_FLAG : CIN_ONE;
      end
      OP_DEC, OP_DECC: begin
        // operand + all-ones + cin : cin=0 gives -1, cin=C gives -(1-C)
        ctrl_o.use_adder = 1'b1;
        ctrl_o.sub       = 1'b1;
        ctrl_o.b_zero    = 1'b1;
        ctrl_o.upd_cv    = 1'b1;
        ctrl_o.cin_sel   = (op_i == OP_DECC) ? CIN_FLAG : CIN_ZERO;
      end
      OP_AND: ctrl_o.log_fn = LOG_AND;
      OP_OR:  ctrl_o.log_fn = LOG_OR;
      OP_XOR: ctrl_o.log_fn = LOG_XOR;
      OP_CMP, OP_CMPS: begin
        ctrl_o.use_adder  = 1'b1;
        ctrl_o.sub        = 1'b1;
        ctrl_o.upd_cv     = 1'b1;
        ctrl_o.is_cmp     = 1'b1;
        ctrl_o.wr_reg     = 1'b0;
        ctrl_o.cin_sel    = CIN_ONE;
        ctrl_o.signed_cmp = (op_i == OP_CMPS);
      end
      OP_TSTB: begin
        ctrl_o.is_bit = 1'b1;
        ctrl_o.bit_fn = BIT_TST;
        ctrl_o.wr_reg = 1'b0;
      end
      OP_SETB: begin
        ctrl_o.is_bit = 1'b1;
        ctrl_o.bit_fn = BIT_SET;
      end
      OP_CLRB: begin
        ctrl_o.is_bit = 1'b1;
        ctrl_o.bit_fn = BIT_CLR;
      end
      OP_INVB: begin
        ctrl_o.is_bit = 1'b1;
        ctrl_o.bit_fn = BIT_INV;
      end
      default: begin
        ctrl_o.valid  = 1'b0;
        ctrl_o.wr_reg = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  // subtraction as a + ~b + cin, so cout is the inverted borrow
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] opnd_i,
  input  log_fn_e      log_fn_i,
  input  bit_fn_e      bit_fn_i,
  input  logic         is_bit_i,
  output logic [W-1:0] res_o
);

  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  logic [IDX_W-1:0] idx;
  logic [W-1:0]     mask;
  logic [W-1:0]     log_res;
  logic [W-1:0]     bit_res;

  assign idx = opnd_i[IDX_W-1:0];

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (idx == IDX_W'(i));
  end

  always_comb begin
    case (log_fn_i)
      LOG_OR:  log_res = reg_i | opnd_i;
      LOG_XOR: log_res = reg_i ^ opnd_i;
      default: log_res = reg_i & opnd_i;
    endcase
  end

  always_comb begin
    case (bit_fn_i)
      BIT_SET: bit_res = reg_i | mask;
      BIT_CLR: bit_res = reg_i & ~mask;
      BIT_INV: bit_res = reg_i ^ mask;
      default: bit_res = reg_i & mask;
    endcase
  end

  assign res_o = is_bit_i ? bit_res : log_res;

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exec_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    reg_i,
  input  logic [W-1:0]    opnd_i,
  output logic [W-1:0]    res_o,
  output logic            res_we_o,
  output logic [W-1:0]    acc_o,
  output logic            c_o,
  output logic            v_o,
  output logic            z_o
);

  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};

  alu_ctrl_t    ctrl;
  logic [W-1:0] op_a, op_b, add_a, add_b, sgn_flip;
  logic         cin;
  logic [W-1:0] sum, lres, nxt_a;
  logic         cout, ovf;
  logic         nxt_c, nxt_v, nxt_z;

  alu8_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign op_a     = ctrl.a_is_reg ? reg_i : opnd_i;
  assign op_b     = ctrl.b_zero ? '0 : (ctrl.a_is_reg ? opnd_i : reg_i);
  // signed compare: bias both sides so an unsigned borrow orders them signed
  assign sgn_flip = ctrl.signed_cmp ? SIGN_BIT : '0;
  assign add_a    = op_a ^ sgn_flip;
  assign add_b    = op_b ^ sgn_flip;

  always_comb begin
    case (ctrl.cin_sel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = c_o;
      default:  cin = 1'b0;
    endcase
  end

  alu8_addsub #(.W(W)) u_add (
    .a_i    (add_a),
    .b_i    (add_b),
    .sub_i  (ctrl.sub),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  alu8_bitops #(.W(W)) u_bit (
    .reg_i    (reg_i),
    .opnd_i   (opnd_i),
    .log_fn_i (ctrl.log_fn),
    .bit_fn_i (ctrl.bit_fn),
    .is_bit_i (ctrl.is_bit),
    .res_o    (lres)
  );

  assign nxt_a = ctrl.use_adder ? sum : lres;
  assign nxt_z = (nxt_a == '0);
  assign nxt_c = ctrl.upd_cv ? cout : c_o;

  always_comb begin
    if (!ctrl.upd_cv)     nxt_v = v_o;
    else if (ctrl.is_cmp) nxt_v = cout & ~nxt_z;
    else                  nxt_v = ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o    <= '0;
      res_o    <= '0;
      res_we_o <= 1'b0;
      c_o      <= 1'b0;
      v_o      <= 1'b0;
      z_o      <= 1'b1;
    end else begin
      res_we_o <= 1'b0;
      if (exec_i && ctrl.valid) begin
        acc_o <= nxt_a;
        c_o   <= nxt_c;
        v_o   <= nxt_v;
        z_o   <= nxt_z;
        if (ctrl.wr_reg) begin
          res_o    <= nxt_a;
          res_we_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exec_i,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    res_o,
  input logic            res_we_o,
  input logic [W-1:0]    acc_o,
  input logic            c_o,
  input logic            v_o,
  input logic            z_o
);

  logic is_logic, is_cmp, undef_op;

  assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) ||
                    (op_i == OP_TSTB) || (op_i == OP_SETB) ||
                    (op_i == OP_CLRB) || (op_i == OP_INVB);
  assign is_cmp   = (op_i == OP_CMP) || (op_i == OP_CMPS);
  assign undef_op = (op_i > OP_INVB);

  a_r10_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> (res_o == acc_o));

  a_r5_keep_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && is_logic) |=> ($stable(c_o) && $stable(v_o)));

  a_r6_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && (is_cmp || op_i == OP_TSTB)) |=> !res_we_o);

  a_r6_v_rule: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && is_cmp) |=> (!v_o || (c_o && !z_o)));

  a_r8_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && op_i == OP_TSTB) |=> ($countones(acc_o) <= 1));

  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_i || undef_op) |=> ($stable(acc_o) && $stable(c_o) && $stable(v_o) &&
                               $stable(z_o) && $stable(res_o) && !res_we_o));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .exec_i   (exec_i),
  .op_i     (op_i),
  .res_o    (res_o),
  .res_we_o (res_we_o),
  .acc_o    (acc_o),
  .c_o      (c_o),
  .v_o      (v_o),
  .z_o      (z_o)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       exec_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] reg_i = '0;
  logic [7:0] opnd_i = '0;
  logic [7:0] res_o, acc_o;
  logic       res_we_o, c_o, v_o, z_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic mc = 1'b0, mv = 1'b0;

  always #2.5 clk_i = ~clk_i;

  alu8_core #(.W(8)) u_alu8_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .exec_i(exec_i), .op_i(op_i),
    .reg_i(reg_i), .opnd_i(opnd_i), .res_o(res_o), .res_we_o(res_we_o),
    .acc_o(acc_o), .c_o(c_o), .v_o(v_o), .z_o(z_o)
  );

  // {op, reg, opnd, cin, a, c, v, z, we}
  localparam int NV = 26;
  localparam logic [33:0] VEC [NV] = '{
    {5'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd0,  8'h80, 8'h80, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'd2,  8'h05, 8'h03, 1'b1, 8'hFE, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd3,  8'h03, 8'h05, 1'b0, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd4,  8'h80, 8'h01, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd5,  8'h10, 8'h10, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd5,  8'h10, 8'h10, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd6,  8'h55, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd6,  8'h55, 8'h80, 1'b0, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd7,  8'h00, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd7,  8'h00, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd7,  8'h00, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd8,  8'hF0, 8'h0F, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd9,  8'hA0, 8'h05, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd10, 8'h3C, 8'h3C, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd11, 8'h20, 8'h30, 1'b0, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd11, 8'h30, 8'h20, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd11, 8'h44, 8'h44, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {5'd12, 8'h01, 8'h80, 1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd12, 8'hFF, 8'h01, 1'b0, 8'h02, 1'b1, 1'b1, 1'b0, 1'b0},
    {5'd13, 8'h08, 8'h03, 1'b1, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd13, 8'hF7, 8'h03, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd14, 8'h00, 8'h07, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {5'd15, 8'h01, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd16, 8'h5A, 8'h0A, 1'b0, 8'h5E, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  function automatic string tag_of(input int op);
    if (op <= 1)  return "R2";
    if (op <= 5)  return "R3";
    if (op <= 7)  return "R4";
    if (op <= 10) return "R5";
    if (op == 11) return "R6";
    if (op == 12) return "R7";
    if (op == 13) return "R8";
    return "R9";
  endfunction

  function automatic int sx(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // independent model: returns {a, c, v, z, we}
  function automatic logic [11:0] ref_op(input int op, input int r, input int o,
                                         input logic pc, input logic pv);
    int t, st, ci, ks;
    logic [7:0] a;
    logic c, v, we;
    ci = pc ? 1 : 0;
    c = pc; v = pv; we = 1'b1; t = 0; ks = o % 8;
    case (op)
      0, 1: begin
        t  = r + o + ((op == 1) ? ci : 0);
        st = sx(r) + sx(o) + ((op == 1) ? ci : 0);
        c = (t > 255); v = (st > 127) || (st < -128);
      end
      2, 3: begin
        t  = o - r - ((op == 3) ? 1 - ci : 0);
        st = sx(o) - sx(r) - ((op == 3) ? 1 - ci : 0);
        c = (t >= 0); v = (st > 127) || (st < -128);
      end
      4, 5: begin
        t  = r - o - ((op == 5) ? 1 - ci : 0);
        st = sx(r) - sx(o) - ((op == 5) ? 1 - ci : 0);
        c = (t >= 0); v = (st > 127) || (st < -128);
      end
      6, 7: begin
        t  = o - ((op == 7) ? 1 - ci : 1);
        st = sx(o) - ((op == 7) ? 1 - ci : 1);
        c = (t >= 0); v = (st > 127) || (st < -128);
      end
      8:  t = r & o;
      9:  t = r | o;
      10: t = r ^ o;
      11: begin t = o - r; c = (t >= 0); we = 1'b0; end
      12: begin t = o - r; c = (sx(o) >= sx(r)); we = 1'b0; end
      13: begin t = r & (1 << ks); we = 1'b0; end
      14: t = r | (1 << ks);
      15: t = r & ~(1 << ks);
      default: t = r ^ (1 << ks);
    endcase
    a = 8'(t & 255);
    if (op == 11 || op == 12) v = c && (a != 0);
    return {a, c, v, (a == 8'h00), we};
  endfunction

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] op, input logic [7:0] r, input logic [7:0] o);
    @(negedge clk_i);
    exec_i = 1'b1; op_i = op; reg_i = r; opnd_i = o;
    @(negedge clk_i);
    exec_i = 1'b0;
  endtask

  task automatic set_carry(input logic cin);
    do_op(5'd0, cin ? 8'hFF : 8'h00, cin ? 8'h01 : 8'h00);
  endtask

  // compares {a,c,v,z,we}; res checked against a when written
  task automatic check_out(input string tag, input logic [11:0] exp);
    check(tag, {c_o, v_o, res_we_o} == {exp[3], exp[2], exp[0]}, "c/v/we",
          {c_o, v_o, res_we_o}, {exp[3], exp[2], exp[0]});
    check("R1", {acc_o, z_o} == {exp[11:4], exp[1]}, "acc/z",
          {acc_o, z_o}, {exp[11:4], exp[1]});
    if (exp[0])
      check("R10", res_o == exp[11:4], "res", res_o, exp[11:4]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [11:0] e;
    logic [7:0]  a0, r0;
    logic        c0, v0, z0;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12", {acc_o, res_o, c_o, v_o, z_o, res_we_o} == {8'h00, 8'h00, 4'b0010},
          "reset", {acc_o, res_o, c_o, v_o, z_o, res_we_o}, {8'h00, 8'h00, 4'b0010});
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      set_carry(VEC[i][12]);
      do_op(VEC[i][33:29], VEC[i][28:21], VEC[i][20:13]);
      check_out(tag_of(int'(VEC[i][33:29])), VEC[i][11:0]);
    end

    // R11: idle cycles and an undefined opcode leave state alone
    do_op(5'd0, 8'h12, 8'h34);
    a0 = acc_o; c0 = c_o; v0 = v_o; z0 = z_o; r0 = res_o;
    @(negedge clk_i);
    op_i = 5'd1; reg_i = 8'hFF; opnd_i = 8'hFF;
    repeat (3) @(negedge clk_i);
    check("R11", {acc_o, res_o, c_o, v_o, z_o, res_we_o} == {a0, r0, c0, v0, z0, 1'b0},
          "idle", {acc_o, res_o, c_o, v_o, z_o, res_we_o}, {a0, r0, c0, v0, z0, 1'b0});
    do_op(5'd20, 8'h00, 8'h00);
    check("R11", {acc_o, res_o, c_o, v_o, z_o, res_we_o} == {a0, r0, c0, v0, z0, 1'b0},
          "undef", {acc_o, res_o, c_o, v_o, z_o, res_we_o}, {a0, r0, c0, v0, z0, 1'b0});

    // random run; model carries C and V forward from the previous operation
    mc = c_o; mv = v_o;
    for (int n = 0; n < 3000; n++) begin
      int op, r, o;
      op = int'($urandom_range(0, 16));
      r  = int'($urandom_range(0, 255));
      o  = int'($urandom_range(0, 255));
      if (n % 7 == 0) r = (n % 2) ? 8'h80 : 8'h7F;
      e = ref_op(op, r, o, mc, mv);
      do_op(5'(op), 8'(r), 8'(o));
      check_out(tag_of(op), e);
      mc = e[3]; mv = e[2];
    end
    finish_run();
  end

endmodule